// File: doc/BRIEF.md
# Incremental Encoder Position Tracker

This block turns the two phase signals and the once-per-turn index signal of an incremental rotary encoder into a position count, a turn count and a set of event flags. The phase and index inputs are first brought into the clock domain by a two-stage synchroniser. An optional filter can then reject short glitches. After that, each change of the phase pair is decoded as a forward step, a backward step or an illegal jump.

The position counter runs between 0 and a programmable maximum and wraps at both ends. Each wrap also moves a 12-bit rotation counter, which wraps in its turn. Eleven kinds of event are caught in sticky status bits: wraps of either counter, compare hits, index pulses, index pulses seen away from position zero, direction reversals, illegal transitions and movement past a change threshold. A per-bit write-one-to-clear input clears the status bits. A single interrupt line is raised for any status bit whose enable input is set. All configuration arrives on plain input ports.

Top module: `quad_decoder`

## Requirements
- R1: After reset, `pos_o`, `rot_o`, `status_o`, `dir_o` and `irq_o` are all zero.
- R2: With the filtered pair written as {A,B}, the sequence 00→01→11→10→00 is forward and moves the position up by one per change. The reverse sequence moves it down by one. This applies while `scale_i` is 0.
- R3: A forward count at `pos_max_i` wraps the position to 0 and raises position overflow (status bit 2). A backward count at 0 wraps it to `pos_max_i` and raises position underflow (status bit 1).
- R4: Each position overflow adds one to the 12-bit rotation counter, and each position underflow subtracts one. Going from 0xFFF to 0 raises rotation overflow (bit 6). Going from 0 to 0xFFF raises rotation underflow (bit 7). The rotation counter does not change otherwise.
- R5: When A and B both change in the same cycle, illegal-transition (bit 0) is raised and the position does not change.
- R6: With `scale_i` at 1, only changes of A count. B changes are decoded for direction but leave the position unchanged.
- R7: A legal change whose direction differs from the last recorded one raises direction-change (bit 4). The first legal change after reset only records the direction. `dir_o` is 1 for forward.
- R8: Position-compare (bit 5) is raised when a count makes the position equal to `pos_cmp_i`. Rotation-compare (bit 10) is raised when a wrap makes the rotation counter equal to `rot_cmp_i`.
- R9: A rising edge on the filtered index raises index (bit 8) while `idx_en_i` is 1, and also index-error (bit 9) if the position is not 0 at that time. With `idx_en_i` at 0, neither is raised.
- R10: Position-change (bit 3) is raised when the net count since the last such event (or since reset) reaches 2^`chg_lvl_i` in either direction. The reference then restarts at the current position.
- R11: Status bits are sticky until a 1 is written to the matching `status_clr_i` bit. A new event in the same cycle as its clear wins. `irq_o` is the OR of all `status_o & int_en_i`.
- R12: With `dbn_en_i` at 1, a filtered input takes a new level only after that level has been seen on 4 consecutive cycles. Shorter pulses are dropped. With `dbn_en_i` at 0, the synchronised level passes straight through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pha_i | input | 1 | Encoder phase A |
| phb_i | input | 1 | Encoder phase B |
| idx_i | input | 1 | Encoder index pulse |
| dbn_en_i | input | 1 | Glitch filter enable |
| scale_i | input | 1 | 0: count every phase change, 1: count A changes only |
| idx_en_i | input | 1 | Index detection enable |
| pos_max_i | input | POS_W | Position wrap maximum |
| pos_cmp_i | input | POS_W | Position compare value |
| rot_cmp_i | input | ROT_W | Rotation compare value |
| chg_lvl_i | input | LVL_W | Change threshold select (2^n counts) |
| int_en_i | input | 11 | Per-event interrupt enables |
| status_clr_i | input | 11 | Per-bit write-one-to-clear |
| status_o | output | 11 | Sticky event status |
| pos_o | output | POS_W | Position counter |
| rot_o | output | ROT_W | Rotation counter |
| dir_o | output | 1 | Last decoded direction (1 = forward) |
| irq_o | output | 1 | Combined interrupt |

## Verification
A wrong decoder state, such as a stale previous phase pair, shows as a position that is off by one, or as a spurious illegal or direction bit. Either appears on the ports one cycle after the filtered phase change, or four filter cycles later when the filter is on. A wrong reference in the change accumulator, or a misplaced rotation update, shows only several steps later, as a threshold bit that fires early or late or as a turn count that drifts. The bench therefore walks long step sequences and compares the counters after every step against an arithmetic model.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    localparam int EV_N       = 11;
    localparam int EV_ILLEGAL = 0;
    localparam int EV_POS_UNF = 1;
    localparam int EV_POS_OVF = 2;
    localparam int EV_POS_CHG = 3;
    localparam int EV_DIR     = 4;
    localparam int EV_POS_CMP = 5;
    localparam int EV_ROT_OVF = 6;
    localparam int EV_ROT_UNF = 7;
    localparam int EV_IDX     = 8;
    localparam int EV_IDX_ERR = 9;
    localparam int EV_ROT_CMP = 10;

    typedef logic [EV_N-1:0] ev_vec_t;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2,
        STEP_BAD  = 2'd3
    } step_e;

endpackage

// File: rtl/qdec_in_filter.sv
module qdec_in_filter #(
    parameter int N       = 3,
    parameter int DEB_CYC = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dbn_en_i,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] clean_o
);

    localparam int CNT_W = $clog2(DEB_CYC + 1);

    for (genvar g = 0; g < N; g++) begin : g_lane
        typedef struct packed {
            logic             s1;
            logic             s2;
            logic             lvl;
            logic [CNT_W-1:0] cnt;
        } lane_t;

        lane_t lane_q, lane_d;

        always_comb begin
            lane_d    = lane_q;
            lane_d.s1 = raw_i[g];
            lane_d.s2 = lane_q.s1;
            if (!dbn_en_i) begin
                lane_d.lvl = lane_q.s2;
                lane_d.cnt = '0;
            end else if (lane_q.s2 == lane_q.lvl) begin
                lane_d.cnt = '0;
            end else if (lane_q.cnt == CNT_W'(DEB_CYC - 1)) begin
                lane_d.lvl = lane_q.s2;
                lane_d.cnt = '0;
            end else begin
                lane_d.cnt = lane_q.cnt + CNT_W'(1);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lane_q <= '0;
            else        lane_q <= lane_d;
        end

        assign clean_o[g] = lane_q.lvl;

        AST_DBN_OFF_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
            !dbn_en_i |=> (lane_q.lvl == $past(lane_q.s2))); // R12

        AST_DBN_NEEDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (dbn_en_i && (lane_d.lvl != lane_q.lvl)) |-> (lane_q.s2 == $past(lane_q.s2))); // R12
    end

endmodule

// File: rtl/qdec_track.sv
module qdec_track
    import qdec_pkg::*;
#(
    parameter int POS_W = 16,
    parameter int ROT_W = 12,
    parameter int LVL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_i,
    input  logic             b_i,
    input  logic             idx_i,
    input  logic             scale_i,
    input  logic             idx_en_i,
    input  logic [POS_W-1:0] pos_max_i,
    input  logic [POS_W-1:0] pos_cmp_i,
    input  logic [ROT_W-1:0] rot_cmp_i,
    input  logic [LVL_W-1:0] chg_lvl_i,
    output logic [POS_W-1:0] pos_o,
    output logic [ROT_W-1:0] rot_o,
    output logic             dir_o,
    output ev_vec_t          ev_o
);

    localparam int ACC_W = (1 << LVL_W) + 1;

    typedef struct packed {
        logic [1:0]       ab;
        logic             idx;
        logic [POS_W-1:0] pos;
        logic [ROT_W-1:0] rot;
        logic             dir;
        logic             dir_known;
        logic [ACC_W-1:0] acc;
    } trk_t;

    trk_t             trk_q, trk_d;
    ev_vec_t          ev;
    step_e            step;
    logic [1:0]       ab_now, flip;
    logic             dir_up, count_en, rot_upd;
    logic [ACC_W-1:0] acc_nxt, acc_mag, thr;

    always_comb begin
        trk_d    = trk_q;
        ev       = '0;
        rot_upd  = 1'b0;
        ab_now   = {a_i, b_i};
        flip     = ab_now ^ trk_q.ab;
        dir_up   = trk_q.ab[1] ^ ab_now[0];
        thr      = ACC_W'(1) << chg_lvl_i;
        acc_nxt  = trk_q.acc;
        acc_mag  = '0;

        if (flip == 2'b11)      step = STEP_BAD;
        else if (flip != 2'b00) step = dir_up ? STEP_UP : STEP_DN;
        else                    step = STEP_NONE;

        count_en = ((step == STEP_UP) || (step == STEP_DN)) && (!scale_i || flip[1]);

        trk_d.ab  = ab_now;
        trk_d.idx = idx_i;

        if (step == STEP_BAD) ev[EV_ILLEGAL] = 1'b1;

        if ((step == STEP_UP) || (step == STEP_DN)) begin
            if (trk_q.dir_known && (dir_up != trk_q.dir)) ev[EV_DIR] = 1'b1;
            trk_d.dir       = dir_up;
            trk_d.dir_known = 1'b1;
        end

        if (count_en) begin
            if (dir_up) begin
                acc_nxt = trk_q.acc + ACC_W'(1);
                if (trk_q.pos == pos_max_i) begin
                    trk_d.pos       = '0;
                    ev[EV_POS_OVF]  = 1'b1;
                    trk_d.rot       = trk_q.rot + ROT_W'(1);
                    rot_upd         = 1'b1;
                    if (trk_q.rot == '1) ev[EV_ROT_OVF] = 1'b1;
                end else begin
                    trk_d.pos = trk_q.pos + POS_W'(1);
                end
            end else begin
                acc_nxt = trk_q.acc - ACC_W'(1);
                if (trk_q.pos == '0) begin
                    trk_d.pos       = pos_max_i;
                    ev[EV_POS_UNF]  = 1'b1;
                    trk_d.rot       = trk_q.rot - ROT_W'(1);
                    rot_upd         = 1'b1;
                    if (trk_q.rot == '0) ev[EV_ROT_UNF] = 1'b1;
                end else begin
                    trk_d.pos = trk_q.pos - POS_W'(1);
                end
            end

            if (trk_d.pos == pos_cmp_i)             ev[EV_POS_CMP] = 1'b1;
            if (rot_upd && (trk_d.rot == rot_cmp_i)) ev[EV_ROT_CMP] = 1'b1;

            acc_mag = acc_nxt[ACC_W-1] ? (~acc_nxt + ACC_W'(1)) : acc_nxt;
            if (acc_mag >= thr) begin
                ev[EV_POS_CHG] = 1'b1;
                trk_d.acc      = '0;
            end else begin
                trk_d.acc      = acc_nxt;
            end
        end

        if (idx_en_i && idx_i && !trk_q.idx) begin
            ev[EV_IDX] = 1'b1;
            if (trk_q.pos != '0) ev[EV_IDX_ERR] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign pos_o = trk_q.pos;
    assign rot_o = trk_q.rot;
    assign dir_o = trk_q.dir;
    assign ev_o  = ev;

    AST_BAD_KEEPS_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_BAD) |=> $stable(trk_q.pos)); // R5

    AST_OVF_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ev[EV_POS_OVF] |=> (trk_q.pos == '0)); // R3

    AST_UNF_TO_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        ev[EV_POS_UNF] |=> (trk_q.pos == $past(pos_max_i))); // R3

    AST_ROT_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev[EV_POS_OVF] && !ev[EV_POS_UNF]) |=> $stable(trk_q.rot)); // R4

    AST_IDX_ERR_NEEDS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        ev[EV_IDX_ERR] |-> ev[EV_IDX]); // R9

endmodule

// File: rtl/quad_decoder.sv
module quad_decoder
    import qdec_pkg::*;
#(
    parameter int POS_W   = 16,
    parameter int ROT_W   = 12,
    parameter int LVL_W   = 2,
    parameter int DEB_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pha_i,
    input  logic             phb_i,
    input  logic             idx_i,
    input  logic             dbn_en_i,
    input  logic             scale_i,
    input  logic             idx_en_i,
    input  logic [POS_W-1:0] pos_max_i,
    input  logic [POS_W-1:0] pos_cmp_i,
    input  logic [ROT_W-1:0] rot_cmp_i,
    input  logic [LVL_W-1:0] chg_lvl_i,
    input  logic [EV_N-1:0]  int_en_i,
    input  logic [EV_N-1:0]  status_clr_i,
    output logic [EV_N-1:0]  status_o,
    output logic [POS_W-1:0] pos_o,
    output logic [ROT_W-1:0] rot_o,
    output logic             dir_o,
    output logic             irq_o
);

    logic [2:0] clean;
    ev_vec_t    ev;
    ev_vec_t    status_q, status_d;

    qdec_in_filter #(
        .N       (3),
        .DEB_CYC (DEB_CYC)
    ) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .dbn_en_i (dbn_en_i),
        .raw_i    ({idx_i, phb_i, pha_i}),
        .clean_o  (clean)
    );

    qdec_track #(
        .POS_W (POS_W),
        .ROT_W (ROT_W),
        .LVL_W (LVL_W)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_i       (clean[0]),
        .b_i       (clean[1]),
        .idx_i     (clean[2]),
        .scale_i   (scale_i),
        .idx_en_i  (idx_en_i),
        .pos_max_i (pos_max_i),
        .pos_cmp_i (pos_cmp_i),
        .rot_cmp_i (rot_cmp_i),
        .chg_lvl_i (chg_lvl_i),
        .pos_o     (pos_o),
        .rot_o     (rot_o),
        .dir_o     (dir_o),
        .ev_o      (ev)
    );

    always_comb begin
        status_d = (status_q & ~status_clr_i) | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign status_o = status_q;
    assign irq_o    = |(status_q & int_en_i);

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status_o) & ~$past(status_clr_i) & ~status_o) == '0)); // R11

endmodule

// File: tb/quad_decoder_tb.sv
`timescale 1ns/1ps
module quad_decoder_tb;

    localparam int B_ILL = 0, B_PUNF = 1, B_POVF = 2, B_CHG = 3, B_DIR = 4, B_PCMP = 5;
    localparam int B_ROVF = 6, B_RUNF = 7, B_IDX = 8, B_IERR = 9, B_RCMP = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pha = 1'b0, phb = 1'b0, idx = 1'b0;
    logic        dbn_en = 1'b0, scale = 1'b0, idx_en = 1'b0;
    logic [15:0] pos_max = 16'd5, pos_cmp = 16'hFFFF;
    logic [11:0] rot_cmp = 12'hABC;
    logic [1:0]  chg_lvl = 2'd0;
    logic [10:0] int_en = '0, status_clr = '0;
    logic [10:0] status;
    logic [15:0] pos;
    logic [11:0] rot;
    logic        dir, irq;

    int n_cmp = 0, n_bad = 0;
    int k = 0, exp_pos = 0, exp_rot = 0, pmax = 5;
    logic [1:0] ab = 2'b00;

    always #2.5 clk = ~clk;

    quad_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .pha_i(pha), .phb_i(phb), .idx_i(idx),
        .dbn_en_i(dbn_en), .scale_i(scale), .idx_en_i(idx_en),
        .pos_max_i(pos_max), .pos_cmp_i(pos_cmp), .rot_cmp_i(rot_cmp),
        .chg_lvl_i(chg_lvl), .int_en_i(int_en), .status_clr_i(status_clr),
        .status_o(status), .pos_o(pos), .rot_o(rot), .dir_o(dir), .irq_o(irq)
    );

    task automatic chk(string tag, longint act, longint exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] gray(int i);
        case (i)
            0: return 2'b00;
            1: return 2'b01;
            2: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    task automatic settle();
        repeat (10) @(negedge clk);
    endtask

    task automatic mstep(bit up);
        logic [1:0] old;
        old = ab;
        k   = up ? (k + 1) % 4 : (k + 3) % 4;
        ab  = gray(k);
        pha = ab[1];
        phb = ab[0];
        if (!scale || (old[1] != ab[1])) begin
            if (up) begin
                if (exp_pos == pmax) begin exp_pos = 0; exp_rot = (exp_rot + 1) % 4096; end
                else exp_pos++;
            end else begin
                if (exp_pos == 0) begin exp_pos = pmax; exp_rot = (exp_rot + 4095) % 4096; end
                else exp_pos--;
            end
        end
        settle();
    endtask

    task automatic clr_all();
        status_clr = '1;
        @(negedge clk);
        status_clr = '0;
        @(negedge clk);
    endtask

    task automatic idx_pulse(int len);
        idx = 1'b1;
        repeat (len) @(negedge clk);
        idx = 1'b0;
        settle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 pos", pos, 0);
        chk("R1 rot", rot, 0);
        chk("R1 status", status, 0);
        chk("R1 irq", irq, 0);
        chk("R1 dir", dir, 0);
        rst_n = 1'b1;
        settle();

        // R2 R3 R4: forward sweep through several wraps
        for (int i = 0; i < 20; i++) begin
            mstep(1'b1);
            chk("R2 fwd pos", pos, exp_pos);
            chk("R4 fwd rot", rot, exp_rot);
        end
        chk("R4 rot after 20", rot, 3);
        chk("R3 ovf flag", status[B_POVF], 1);
        chk("R7 no dir event on first run", status[B_DIR], 0);
        chk("R7 dir forward", dir, 1);
        chk("R11 irq masked", irq, 0);

        clr_all();
        chk("R11 clear all", status, 0);
        mstep(1'b0);
        chk("R7 reversal flag", status[B_DIR], 1);
        chk("R7 dir backward", dir, 0);
        chk("R2 back pos", pos, exp_pos);

        // R3 R4: backward sweep through underflows
        clr_all();
        for (int i = 0; i < 14; i++) begin
            mstep(1'b0);
            chk("R2 back pos", pos, exp_pos);
            chk("R4 back rot", rot, exp_rot);
        end
        chk("R3 unf flag", status[B_PUNF], 1);

        // R8 position compare
        while (exp_pos != 4) mstep(1'b1);
        pos_cmp = 16'd2;
        clr_all();
        mstep(1'b0);
        chk("R8 no early cmp", status[B_PCMP], 0);
        mstep(1'b0);
        chk("R8 cmp at 2", status[B_PCMP], 1);
        pos_cmp = 16'hFFFF;

        // R5 illegal jump
        clr_all();
        ab  = ~ab;
        k   = (k + 2) % 4;
        pha = ab[1];
        phb = ab[0];
        settle();
        chk("R5 illegal flag", status[B_ILL], 1);
        chk("R5 pos held", pos, exp_pos);

        // R6 A-only counting
        scale = 1'b1;
        for (int i = 0; i < 10; i++) begin
            mstep(1'b1);
            chk("R6 half-rate pos", pos, exp_pos);
        end
        scale = 1'b0;

        // R10 change threshold
        clr_all();
        mstep(1'b1);
        chk("R10 level0 single", status[B_CHG], 1);
        chg_lvl = 2'd2;
        clr_all();
        for (int i = 0; i < 3; i++) mstep(1'b1);
        chk("R10 below 4", status[B_CHG], 0);
        mstep(1'b1);
        chk("R10 at 4", status[B_CHG], 1);
        clr_all();
        mstep(1'b1); mstep(1'b1); mstep(1'b0); mstep(1'b0);
        chk("R10 net zero", status[B_CHG], 0);
        for (int i = 0; i < 3; i++) mstep(1'b0);
        chk("R10 back 3", status[B_CHG], 0);
        mstep(1'b0);
        chk("R10 back 4", status[B_CHG], 1);
        chg_lvl = 2'd0;

        // R9 index handling
        idx_en = 1'b1;
        if (exp_pos == 0) mstep(1'b1);
        clr_all();
        idx_pulse(3);
        chk("R9 idx flag", status[B_IDX], 1);
        chk("R9 idx error", status[B_IERR], 1);
        while (exp_pos != 0) mstep(1'b1);
        clr_all();
        idx_pulse(3);
        chk("R9 idx at zero", status[B_IDX], 1);
        chk("R9 no err at zero", status[B_IERR], 0);
        idx_en = 1'b0;
        clr_all();
        idx_pulse(3);
        chk("R9 disabled idx", status[B_IDX], 0);
        chk("R9 disabled err", status[B_IERR], 0);

        // R11 interrupt gating and per-bit clear
        idx_en = 1'b1;
        clr_all();
        int_en = 11'b1 << B_IDX;
        @(negedge clk);
        chk("R11 irq idle", irq, 0);
        idx_pulse(3);
        chk("R11 irq set", irq, 1);
        int_en = '0;
        @(negedge clk);
        chk("R11 irq gated", irq, 0);
        chk("R11 sticky", status[B_IDX], 1);
        int_en = 11'b1 << B_IDX;
        status_clr = 11'b1 << B_ILL;
        @(negedge clk);
        status_clr = '0;
        @(negedge clk);
        chk("R11 other clear no effect", irq, 1);
        status_clr = 11'b1 << B_IDX;
        @(negedge clk);
        status_clr = '0;
        @(negedge clk);
        chk("R11 clear bit", status[B_IDX], 0);
        chk("R11 irq drop", irq, 0);
        int_en = '0;

        // R12 debounce
        dbn_en = 1'b1;
        settle();
        clr_all();
        idx_pulse(2);
        chk("R12 glitch dropped", status[B_IDX], 0);
        idx_pulse(8);
        chk("R12 long pulse kept", status[B_IDX], 1);
        for (int i = 0; i < 6; i++) begin
            mstep(1'b1);
            chk("R12 filtered step", pos, exp_pos);
        end
        dbn_en = 1'b0;
        settle();
        clr_all();
        idx_pulse(2);
        chk("R12 pass-through", status[B_IDX], 1);
        idx_en = 1'b0;

        // R4 R8: rotation wraps with a single-count range
        while (exp_pos != 0) mstep(1'b0);
        pos_max = 16'd0;
        pmax    = 0;
        while (exp_rot != 0) mstep(1'b0);
        clr_all();
        mstep(1'b0);
        chk("R4 rot to FFF", rot, 12'hFFF);
        chk("R4 rot unf flag", status[B_RUNF], 1);
        chk("R3 unf zero range", pos, 0);
        clr_all();
        mstep(1'b1);
        chk("R4 rot to 0", rot, 0);
        chk("R4 rot ovf flag", status[B_ROVF], 1);
        rot_cmp = 12'd3;
        clr_all();
        mstep(1'b1); mstep(1'b1);
        chk("R8 rot cmp early", status[B_RCMP], 0);
        mstep(1'b1);
        chk("R8 rot cmp hit", status[B_RCMP], 1);
        chk("R4 rot value", rot, exp_rot);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule